// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a four-way set-associative data cache placed between a processor port that issues single-word reads and writes on byte addresses and a slower main memory that moves whole 64-byte lines. Each way of each set holds a line of data, its tag, a valid flag and a modified flag. A request is looked up by comparing the tags of all ways in the indexed set. A hit completes from the cache. A miss runs through a fixed sequence of states.

A mode input selects how writes are handled. In write-back mode (`wb_mode`=1), writes allocate a line and stay in the cache until that line is evicted. In write-through mode (`wb_mode`=0), every write also goes to memory, and a write miss bypasses the cache. The victim way for a full set comes from an external replacement unit through `repl_way`. Empty ways are always used first.

The controller states are:
- ST_IDLE: lookup. A hit completes here.
- ST_WTHRU: single-word memory write in write-through mode.
- ST_EVICT: whole-line write-back of a modified victim.
- ST_FILL: line read from memory.
- ST_DONE: completion after a memory sequence.

The transitions are:
- IDLE→IDLE: read hit, or write hit in write-back mode.
- IDLE→WTHRU: any write in write-through mode.
- IDLE→EVICT: miss whose victim is valid and modified.
- IDLE→FILL: miss whose victim is clean or empty.
- EVICT→FILL: on acknowledge.
- FILL→DONE: on acknowledge.
- WTHRU→DONE: on acknowledge.
- DONE→IDLE: always.

Top module: `assoc_cache_ctrl`

## Requirements
- R1: Address fields are split as follows. Bits [5:0] are the byte offset, and bits [5:2] select one of 16 32-bit words in the line. The next log2(SETS) bits are the set index, which is [13:6] for 256 sets and [9:6] for the default 16 sets. The remaining upper bits are the tag. Processor addresses are word aligned.
- R2: On a read hit, `cpu_ready` rises in the same cycle as `cpu_req`. `cpu_rvalid` and `cpu_rdata` follow one cycle after acceptance. No memory transfer takes place.
- R3: In write-back mode, a write hit updates only the cached word, sets that line's modified flag, and issues no memory transfer.
- R4: On a miss whose victim is valid and modified, the whole line is written to the victim's own line address (`mem_wmask` all ones) before the line read for the new address is issued.
- R5: On a miss whose victim is clean, the victim is dropped without any memory write.
- R6: After a refill completes, a pending write is merged into the fetched line, or the requested word of the fetched line is returned for a read.
- R7: In write-through mode, a write hit updates the cached word and also issues one memory write. That write has exactly one `mem_wmask` bit set, bit i for word i of the line.
- R8: In write-through mode, a write miss issues one masked memory write and allocates no line, so a later read of that address misses.
- R9: On a miss, the lowest-numbered empty way of the set receives the new line, and `repl_way` is ignored. When all ways are valid, the way named by `repl_way` is evicted.
- R10: Reset clears every valid and modified flag, so every access after reset misses. After reset, `cpu_ready`, `cpu_rvalid` and `mem_req` are low.
- R11: `mem_req` is held, with `mem_addr` stable, until `mem_ack` is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back with allocate, 0 = write-through with write-around |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| repl_way | input | 2 | Victim way from the replacement unit |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read completes |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 512 | Line write data |
| mem_wmask | output | 16 | Per-word write enable |
| mem_ack | input | 1 | Memory completes the transfer at this edge |
| mem_rdata | input | 512 | Line read data, valid with `mem_ack` |

## Verification
Some internal faults show at the next access to the same set. A lost or stuck modified flag shows there as a missing or extra line write, or as stale data read back after the victim is refilled. A wrong valid flag or a wrong tag shows at the very next access to that address as a hit that should miss, or a miss that should hit. That access either skips the expected memory read or performs an unexpected one. A wrong victim choice is seen only when a later access needs the dropped line, as an extra refill or an eviction at the wrong address. The bench therefore counts memory reads and writes per access, checks write addresses and masks, and replays lines after they have been evicted.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WTHRU,
        ST_EVICT,
        ST_FILL,
        ST_DONE
    } cstate_e;

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic [WAY_W-1:0]            repl_way,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            victim_way
);

    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] first_free;
    logic             any_free;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == req_tag);
    end

    assign hit      = |match;
    assign any_free = ~&way_valid;

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end

    always_comb begin
        first_free = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) first_free = WAY_W'(i);
        end
    end

    assign victim_way = any_free ? first_free : repl_way;

    // R1
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 22,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WIDX_W = $clog2(LINE_W / WORD_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    input  logic                        inval_en,
    input  logic [WAY_W-1:0]            inval_way,
    input  logic                        fill_en,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [LINE_W-1:0]           fill_line,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [WIDX_W-1:0]           wr_word,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        wr_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][LINE_W-1:0] rd_line
);

    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (inval_en) begin
                valid_q[rd_set][inval_way] <= 1'b0;
                dirty_q[rd_set][inval_way] <= 1'b0;
            end
            if (fill_en) begin
                valid_q[rd_set][fill_way] <= 1'b1;
                dirty_q[rd_set][fill_way] <= 1'b0;
            end
            if (wr_en && wr_dirty) begin
                dirty_q[rd_set][wr_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[rd_set][fill_way] <= fill_line;
            tag_q[rd_set][fill_way]  <= fill_tag;
        end
        if (wr_en) begin
            data_q[rd_set][wr_way][int'(wr_word) * WORD_W +: WORD_W] <= wr_data;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_rd
        assign rd_tag[g]   = tag_q[rd_set][g];
        assign rd_line[g]  = data_q[rd_set][g];
        assign rd_valid[g] = valid_q[rd_set][g];
        assign rd_dirty[g] = dirty_q[rd_set][g];
    end

    // R10
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dirty & ~rd_valid) == '0);

endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 4,
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int SET_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
    localparam int LINE_W  = LINE_BYTES * 8,
    localparam int WORD_W  = WORD_BYTES * 8,
    localparam int WPL     = LINE_BYTES / WORD_BYTES,
    localparam int WIDX_W  = $clog2(WPL),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int BSEL_W  = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [WAY_W-1:0]  repl_way,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic [WPL-1:0]    mem_wmask,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);

    // address fields
    logic [TAG_W-1:0]  req_tag;
    logic [SET_W-1:0]  req_set;
    logic [WIDX_W-1:0] req_word;

    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_set  = cpu_addr[OFF_W +: SET_W];
    assign req_word = cpu_addr[BSEL_W +: WIDX_W];

    // array read side
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0]             rd_dirty;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            victim_way;

    // controller state
    cstate_e          state_q, state_d;
    logic [WAY_W-1:0] way_q;
    logic             line_ok_q;
    logic             mode_q;
    logic [TAG_W-1:0] vtag_q;
    logic             take_wt;
    logic             take_miss;

    // array write controls
    logic             inval_en;
    logic             fill_en;
    logic             wr_en;
    logic             wr_dirty;
    logic [WAY_W-1:0] use_way;

    cache_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .way_tag    (rd_tag),
        .way_valid  (rd_valid),
        .req_tag    (req_tag),
        .repl_way   (repl_way),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    cache_line_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W),
        .WORD_W (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (req_set),
        .inval_en  (inval_en),
        .inval_way (victim_way),
        .fill_en   (fill_en),
        .fill_way  (way_q),
        .fill_tag  (req_tag),
        .fill_line (mem_rdata),
        .wr_en     (wr_en),
        .wr_way    (use_way),
        .wr_word   (req_word),
        .wr_data   (cpu_wdata),
        .wr_dirty  (wr_dirty),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_line   (rd_line)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            way_q     <= '0;
            line_ok_q <= 1'b0;
            mode_q    <= 1'b0;
            vtag_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_wt) begin
                way_q     <= hit_way;
                line_ok_q <= hit;
                mode_q    <= 1'b0;
            end else if (take_miss) begin
                way_q     <= victim_way;
                line_ok_q <= 1'b1;
                mode_q    <= wb_mode;
                vtag_q    <= rd_tag[victim_way];
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, req_set, OFF_W'(0)};
        mem_wdata = {WPL{cpu_wdata}};
        mem_wmask = '0;
        inval_en  = 1'b0;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        use_way   = way_q;
        take_wt   = 1'b0;
        take_miss = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit && (!cpu_we || wb_mode)) begin
                        cpu_ready = 1'b1;
                        wr_en     = cpu_we;
                        use_way   = hit_way;
                    end else if (cpu_we && !wb_mode) begin
                        take_wt = 1'b1;
                        state_d = ST_WTHRU;
                    end else begin
                        take_miss = 1'b1;
                        inval_en  = 1'b1;
                        state_d   = (rd_valid[victim_way] && rd_dirty[victim_way])
                                    ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wmask = WPL'(1) << req_word;
                if (mem_ack) state_d = ST_DONE;
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vtag_q, req_set, OFF_W'(0)};
                mem_wdata = rd_line[way_q];
                mem_wmask = '1;
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                wr_en     = cpu_we && line_ok_q;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wr_dirty = (state_q == ST_IDLE) || mode_q;

    // read data return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= cpu_ready && !cpu_we;
            if (cpu_ready && !cpu_we) begin
                cpu_rdata <= rd_line[use_way][int'(req_word) * WORD_W +: WORD_W];
            end
        end
    end

    // R1
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[BSEL_W-1:0] == '0));

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we) |=> cpu_rvalid);

    // R4
    evict_full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_req) |-> (mem_we && (&mem_wmask)));

    // R4
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ack) |=> (mem_req && !mem_we));

    // R7
    wt_single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WTHRU && mem_req) |-> (mem_we && $countones(mem_wmask) == 1));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/assoc_cache_ctrl_bench.sv
module assoc_cache_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wb_mode = 1'b1;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [1:0]   repl_way = '0;
    logic         cpu_ready;
    logic         cpu_rvalid;
    logic [31:0]  cpu_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic [15:0]  mem_wmask;
    logic         mem_ack = 1'b0;
    logic [511:0] mem_rdata;

    always #10 clk = ~clk;

    assoc_cache_ctrl u_assoc_cache_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_mode    (wb_mode),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .repl_way   (repl_way),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_wmask  (mem_wmask),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: 1024 lines, address bits [15:6]
    logic [511:0] mem_model [1024];
    int           n_rd = 0;
    int           n_wr = 0;
    logic         first_wr = 1'b0;
    int           n_evt = 0;
    logic [31:0]  last_waddr = '0;
    logic [15:0]  last_wmask = '0;
    int           dly = 0;

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return 32'h5A00_0000 | {16'h0, a[15:2], 2'b00};
    endfunction

    initial begin
        for (int l = 0; l < 1024; l++) begin
            for (int w = 0; w < 16; w++) begin
                mem_model[l][w*32 +: 32] = init_word({16'h0, 10'(l), 4'(w), 2'b00});
            end
        end
    end

    assign mem_rdata = mem_model[mem_addr[15:6]];

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            if (mem_req) begin
                if (n_evt == 0) first_wr <= mem_we;
                n_evt <= n_evt + 1;
                if (mem_we) begin
                    n_wr <= n_wr + 1;
                    last_waddr <= mem_addr;
                    last_wmask <= mem_wmask;
                    for (int w = 0; w < 16; w++) begin
                        if (mem_wmask[w]) mem_model[mem_addr[15:6]][w*32 +: 32] <= mem_wdata[w*32 +: 32];
                    end
                end else begin
                    n_rd <= n_rd + 1;
                end
            end
        end else if (mem_req) begin
            if (dly == 2) begin
                mem_ack <= 1'b1;
                dly <= 0;
            end else begin
                dly <= dly + 1;
            end
        end else if (dly != 0) begin
            // R11: request dropped before acknowledge
            chk("R11", "mem_req held until ack", 64'(mem_req), 64'd1);
            dly <= 0;
        end
    end

    // processor-visible expected contents
    logic [31:0] gold [int];

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        if (gold.exists(int'(a))) return gold[int'(a)];
        return init_word(a);
    endfunction

    task automatic do_access(input logic we, input logic mode, input logic [31:0] addr,
                             input logic [31:0] wdata, input logic [1:0] repl,
                             output logic fast, output logic rv, output logic [31:0] rd);
        int waited;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; wb_mode = mode;
        cpu_addr = addr; cpu_wdata = wdata; repl_way = repl;
        n_evt = 0;
        #2;
        fast = cpu_ready;
        waited = 0;
        while (!cpu_ready && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
        @(posedge clk);
        #1;
        rv = cpu_rvalid;
        rd = cpu_rdata;
        cpu_req = 1'b0;
        if (waited >= 1000) chk("R11", "access timeout", 64'd1, 64'd0);
        if (we) gold[int'(addr)] = wdata;
    endtask

    typedef struct packed {
        logic        we;
        logic        mode;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  repl;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
        logic        fast;
        logic [31:0] waddr;
        logic [15:0] wmask;
    } vec_t;

    // set index addr[9:6], tag addr[31:10] with 16 sets
    localparam vec_t VEC [15] = '{
        '{1'b0, 1'b1, 32'h040,  32'h0,         2'd0, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h04C,  32'h0,         2'd0, 2'd0, 2'd0, 1'b1, 32'h0,    16'h0},
        '{1'b1, 1'b1, 32'h04C,  32'hDEAD_0001, 2'd0, 2'd0, 2'd0, 1'b1, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h04C,  32'h0,         2'd0, 2'd0, 2'd0, 1'b1, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h440,  32'h0,         2'd0, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h840,  32'h0,         2'd0, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'hC40,  32'h0,         2'd0, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h1040, 32'h0,         2'd0, 2'd1, 2'd1, 1'b0, 32'h040,  16'hFFFF},
        '{1'b0, 1'b1, 32'h04C,  32'h0,         2'd1, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b1, 1'b1, 32'h1484, 32'hBEEF_0002, 2'd0, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h1484, 32'h0,         2'd0, 2'd0, 2'd0, 1'b1, 32'h0,    16'h0},
        '{1'b1, 1'b0, 32'h1484, 32'hCAFE_0003, 2'd0, 2'd0, 2'd1, 1'b0, 32'h1480, 16'h0002},
        '{1'b1, 1'b0, 32'h18C0, 32'h1234_0004, 2'd0, 2'd0, 2'd1, 1'b0, 32'h18C0, 16'h0001},
        '{1'b0, 1'b0, 32'h18C0, 32'h0,         2'd0, 2'd1, 2'd0, 1'b0, 32'h0,    16'h0},
        '{1'b0, 1'b1, 32'h1484, 32'h0,         2'd0, 2'd0, 2'd0, 1'b1, 32'h0,    16'h0}
    };

    function automatic string vec_req(input int i);
        case (i)
            0:  return "R6";
            1:  return "R2";
            2:  return "R3";
            3:  return "R3";
            4, 5, 6: return "R9";
            7:  return "R4";
            8:  return "R5";
            9:  return "R6";
            10: return "R1";
            11: return "R7";
            12, 13: return "R8";
            default: return "R7";
        endcase
    endfunction

    initial begin : watchdog
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        nfail++;
        $display("FAIL R11 watchdog: actual %0d cycles expected fewer than 100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic fast, rv;
        logic [31:0] rd;
        int rd0, wr0;

        repeat (3) @(negedge clk);
        // R10: reset state at the ports
        chk("R10", "cpu_ready in reset", 64'(cpu_ready), 64'd0);
        chk("R10", "mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "cpu_rvalid after reset", 64'(cpu_rvalid), 64'd0);
        chk("R10", "mem_req idle after reset", 64'(mem_req), 64'd0);

        for (int i = 0; i < 15; i++) begin
            rd0 = n_rd;
            wr0 = n_wr;
            do_access(VEC[i].we, VEC[i].mode, VEC[i].addr, VEC[i].wdata, VEC[i].repl,
                      fast, rv, rd);
            chk(vec_req(i), $sformatf("vec %0d memory reads", i), 64'(n_rd - rd0), 64'(VEC[i].nrd));
            chk(vec_req(i), $sformatf("vec %0d memory writes", i), 64'(n_wr - wr0), 64'(VEC[i].nwr));
            chk(vec_req(i), $sformatf("vec %0d ready without wait", i), 64'(fast), 64'(VEC[i].fast));
            // R2: rvalid exactly for reads
            chk("R2", $sformatf("vec %0d rvalid", i), 64'(rv), 64'(!VEC[i].we));
            if (!VEC[i].we) begin
                chk(vec_req(i), $sformatf("vec %0d read data", i), 64'(rd), 64'(exp_word(VEC[i].addr)));
            end
            if (VEC[i].wmask != '0) begin
                chk(vec_req(i), $sformatf("vec %0d write address", i), 64'(last_waddr), 64'(VEC[i].waddr));
                chk(vec_req(i), $sformatf("vec %0d write mask", i), 64'(last_wmask), 64'(VEC[i].wmask));
            end
            if (VEC[i].nrd != 0 && VEC[i].nwr != 0) begin
                // R4: write-back precedes refill
                chk("R4", $sformatf("vec %0d first transfer is write", i), 64'(first_wr), 64'd1);
            end
        end

        // R3: memory word untouched by earlier write-back hit until eviction wrote it
        chk("R3", "memory holds evicted dirty word", 64'(mem_model[1][3*32 +: 32]), 64'hDEAD_0001);

        // R10: mid-run reset clears valid flags, resident line misses again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "mem_req during reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        rd0 = n_rd;
        wr0 = n_wr;
        do_access(1'b0, 1'b1, 32'h04C, 32'h0, 2'd0, fast, rv, rd);
        chk("R10", "read after reset misses", 64'(n_rd - rd0), 64'd1);
        chk("R10", "no write-back after reset", 64'(n_wr - wr0), 64'd0);
        chk("R10", "read data after reset", 64'(rd), 64'(exp_word(32'h04C)));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule